// File: doc/BRIEF.md
# Cartridge DMA controller

This block copies bytes between a main-memory byte port and the cartridge side. On the cartridge side sits either a battery-backed save SRAM or a read-only ROM. Software programs a cartridge address, a DRAM address and then one of two length registers. Writing a length register picks the direction and launches the copy. The block works out which cartridge region the address falls in and moves one byte per clock. On the ROM path it trims the length so the copy never runs past the end of the ROM or past the top of DRAM. Each 32-bit word is presented with its byte lanes reversed on both sides.

When the copy is over, the block sets status bits and starts a countdown. Its length depends on the path taken. When the countdown expires it raises an interrupt line, which stays high until software writes the clear command. A length write that arrives while the block is still copying or counting down is dropped.

Top module: `cart_dma`

## Requirements
- R1: When the block is idle, a write to reg_sel 2 (copy DRAM to cartridge) or reg_sel 3 (copy cartridge to DRAM) starts a copy of (reg_wdata[23:0] + 1) bytes, one byte per clock, beginning in the cycle after the write. busy is high from that cycle until the interrupt rises. No byte access happens outside a copy.
- R2: A cartridge address A with 0x08000000 <= A < 0x08010000 selects the save SRAM. In either direction the SRAM byte offset is (A - 0x08000000 + k) wrapped to 15 bits, with cart_rom = 0. The copy length is not trimmed.
- R3: Byte k of a copy uses DRAM byte address (D + k) XOR 3 and cartridge byte address (offset + k) XOR 3. D is the DRAM address register, taken modulo 2^23.
- R4: These starts move no bytes, set status to 01 and raise the interrupt 4097 cycles after the start write: a cartridge-to-DRAM start with a non-SRAM address below 0x10000000 or at or above 0x1FC00000, and a DRAM-to-cartridge start with any non-SRAM address.
- R5: A cartridge-to-DRAM start with 0x10000000 <= A < 0x1FC00000 reads the ROM (cart_rom = 1) at offset A[25:0].
- R6: A ROM copy is trimmed to at most ROM_BYTES - offset bytes. An offset equal to ROM_BYTES moves nothing.
- R7: A ROM copy is trimmed to at most 0x7FFFFF - D bytes.
- R8: A ROM start with an offset above ROM_BYTES, or with D above 0x7FFFFF, moves nothing, sets status to 11 and raises the interrupt one cycle after the start write.
- R9: Status is set at the clock edge that ends the last byte, or at the start edge if no byte moves. SRAM and no-data starts set 01. ROM starts set 11.
- R10: The interrupt rises N + W + 1 cycles after the start write. N is the byte count. W is 4096 for SRAM and no-data starts, and floor(N / 8) for ROM starts.
- R11: A length write while busy is ignored. It changes neither the byte stream nor the interrupt time, and it does not start a later copy.
- R12: A write with reg_sel 4 clears status and the interrupt. If the interrupt fires in the same cycle, the interrupt stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | 0 cart address, 1 DRAM address, 2 length DRAM→cart, 3 length cart→DRAM, 4 clear |
| reg_wdata | input | 32 | Register write data |
| busy | output | 1 | Copy or completion countdown in progress |
| status | output | 2 | Completion status bits |
| irq | output | 1 | Completion interrupt |
| dram_en | output | 1 | DRAM byte access this cycle |
| dram_we | output | 1 | DRAM byte write |
| dram_addr | output | 23 | DRAM byte address |
| dram_wdata | output | 8 | DRAM write byte |
| dram_rdata | input | 8 | DRAM read byte, same cycle |
| cart_en | output | 1 | Cartridge byte access this cycle |
| cart_we | output | 1 | Cartridge byte write (SRAM only) |
| cart_rom | output | 1 | 1 selects ROM, 0 selects SRAM |
| cart_addr | output | 26 | Cartridge byte offset |
| cart_wdata | output | 8 | Cartridge write byte |
| cart_rdata | input | 8 | Cartridge read byte, same cycle |

## Verification
Two events can land on the same clock edge: the interrupt firing at the end of a countdown, and a clear write from software. The bench forces this with a rejected ROM start, whose interrupt fires one cycle after the start. It issues the clear in exactly that cycle. It then expects the interrupt to be high and the status to be zero.

A second collision puts a new length write in the middle of a running copy. A scoreboard checks that every byte access matches the predicted stream and that no extra access shows up. The interrupt time must also stay as predicted.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

    localparam int CART_OFF_W = 26;

    localparam logic [31:0] SRAM_LO = 32'h0800_0000;
    localparam logic [31:0] SRAM_HI = 32'h0801_0000;
    localparam logic [31:0] ROM_LO  = 32'h1000_0000;  // low 26 bits are zero
    localparam logic [31:0] HIGH_LO = 32'h1FC0_0000;

    typedef enum logic [2:0] {
        RS_CART    = 3'd0,
        RS_DRAM    = 3'd1,
        RS_LEN_OUT = 3'd2,
        RS_LEN_IN  = 3'd3,
        RS_CLEAR   = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        P_NONE   = 2'd0,
        P_SRAM   = 2'd1,
        P_ROM    = 2'd2,
        P_REJECT = 2'd3
    } path_e;

    typedef struct packed {
        path_e                  path;
        logic                   to_dram;
        logic [CART_OFF_W-1:0]  cart_off;
        logic [31:0]            dram_base;
        logic [31:0]            nbytes;
        logic [31:0]            delay;
        logic [1:0]             stat;
    } plan_t;

    function automatic plan_t make_plan(
        input logic        to_dram,
        input logic [31:0] cart,
        input logic [31:0] dram,
        input logic [31:0] len_w,
        input logic [31:0] rom_bytes,
        input logic [31:0] dram_limit,
        input logic [31:0] fixed_dly
    );
        plan_t       p;
        logic [32:0] n;
        logic [32:0] off;
        n = {9'd0, len_w[23:0]} + 33'd1;
        p.path      = P_NONE;
        p.to_dram   = to_dram;
        p.cart_off  = '0;
        p.dram_base = dram;
        p.nbytes    = '0;
        p.delay     = fixed_dly;
        p.stat      = 2'b01;
        if (cart >= SRAM_LO && cart < SRAM_HI) begin
            p.path     = P_SRAM;
            p.cart_off = cart[CART_OFF_W-1:0] - SRAM_LO[CART_OFF_W-1:0];
            p.nbytes   = n[31:0];
        end else if (to_dram && cart >= ROM_LO && cart < HIGH_LO) begin
            off    = {7'd0, cart[CART_OFF_W-1:0]};
            p.stat = 2'b11;
            if (off + n > {1'b0, rom_bytes})
                n = {1'b0, rom_bytes} - off;
            if ({1'b0, dram} + n > {1'b0, dram_limit})
                n = {1'b0, dram_limit} - {1'b0, dram};
            if (off > {1'b0, rom_bytes} || dram > dram_limit) begin
                p.path  = P_REJECT;
                p.delay = '0;
            end else begin
                p.path     = P_ROM;
                p.cart_off = off[CART_OFF_W-1:0];
                p.nbytes   = n[31:0];
                p.delay    = {3'd0, n[31:3]};
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/cdma_decode.sv
module cdma_decode
    import cdma_pkg::*;
#(
    parameter logic [31:0] ROM_BYTES   = 32'h0100_0000,
    parameter logic [31:0] DRAM_LIMIT  = 32'h007F_FFFF,
    parameter logic [31:0] FIXED_DELAY = 32'd4096
) (
    input  logic        to_dram,
    input  logic [31:0] cart_addr,
    input  logic [31:0] dram_addr,
    input  logic [31:0] len_word,
    output plan_t       plan
);
    always_comb begin
        plan = make_plan(to_dram, cart_addr, dram_addr, len_word,
                         ROM_BYTES, DRAM_LIMIT, FIXED_DELAY);
    end
endmodule

// File: rtl/cdma_mover.sv
module cdma_mover
    import cdma_pkg::*;
#(
    parameter int DRAM_AW = 23,
    parameter int SRAM_AW = 15
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  to_dram_i,
    input  logic                  rom_i,
    input  logic [CART_OFF_W-1:0] off_i,
    input  logic [DRAM_AW-1:0]    dram_i,
    input  logic [31:0]           nbytes_i,
    output logic                  active_o,
    output logic                  last_o,
    output logic                  dram_en,
    output logic                  dram_we,
    output logic [DRAM_AW-1:0]    dram_addr,
    output logic [7:0]            dram_wdata,
    input  logic [7:0]            dram_rdata,
    output logic                  cart_en,
    output logic                  cart_we,
    output logic                  cart_rom,
    output logic [CART_OFF_W-1:0] cart_addr,
    output logic [7:0]            cart_wdata,
    input  logic [7:0]            cart_rdata
);
    localparam logic [DRAM_AW-1:0]    DLANE = DRAM_AW'(3);
    localparam logic [CART_OFF_W-1:0] CLANE = CART_OFF_W'(3);

    logic                  active;
    logic                  dir_in;
    logic                  rom_q;
    logic [31:0]           rem;
    logic [CART_OFF_W-1:0] coff;
    logic [DRAM_AW-1:0]    dcur;
    logic [CART_OFF_W-1:0] cart_lin;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            dir_in <= 1'b0;
            rom_q  <= 1'b0;
            rem    <= '0;
            coff   <= '0;
            dcur   <= '0;
        end else if (start) begin
            active <= 1'b1;
            dir_in <= to_dram_i;
            rom_q  <= rom_i;
            rem    <= nbytes_i;
            coff   <= off_i;
            dcur   <= dram_i;
        end else if (active) begin
            rem  <= rem - 32'd1;
            coff <= coff + CART_OFF_W'(1);
            dcur <= dcur + DRAM_AW'(1);
            if (rem == 32'd1)
                active <= 1'b0;
        end
    end

    generate
        if (SRAM_AW < CART_OFF_W) begin : g_sram_narrow
            assign cart_lin = rom_q ? coff
                                    : {{(CART_OFF_W-SRAM_AW){1'b0}}, coff[SRAM_AW-1:0]};
        end else begin : g_sram_full
            assign cart_lin = coff;
        end
    endgenerate

    assign active_o   = active;
    assign last_o     = active && (rem == 32'd1);
    assign dram_en    = active;
    assign dram_we    = active && dir_in;
    assign dram_addr  = dcur ^ DLANE;
    assign dram_wdata = cart_rdata;
    assign cart_en    = active;
    assign cart_we    = active && !dir_in;
    assign cart_rom   = active && rom_q;
    assign cart_addr  = cart_lin ^ CLANE;
    assign cart_wdata = dram_rdata;

    AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !active);                                               // R11
    AST_LAST_STOPS: assert property (@(posedge clk) disable iff (rst)
        last_o |=> !active);                                              // R1
    AST_DRAM_STEP: assert property (@(posedge clk) disable iff (rst)
        (active && rem > 32'd1) |=> (dram_addr == ((($past(dram_addr) ^ DLANE) + DRAM_AW'(1)) ^ DLANE))); // R3
    AST_ROM_STEP: assert property (@(posedge clk) disable iff (rst)
        (active && rom_q && rem > 32'd1) |=> (cart_addr == ((($past(cart_addr) ^ CLANE) + CART_OFF_W'(1)) ^ CLANE))); // R5
endmodule

// File: rtl/cdma_timer.sv
module cdma_timer (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [31:0] delay,
    input  logic [1:0]  stat_in,
    input  logic        clear,
    output logic        active_o,
    output logic        irq,
    output logic [1:0]  status
);
    logic        active;
    logic [31:0] cnt;
    logic        fire;

    assign fire     = active && (cnt == 32'd0);
    assign active_o = active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            irq    <= 1'b0;
            status <= 2'b00;
        end else begin
            if (load) begin
                active <= 1'b1;
                cnt    <= delay;
            end else if (fire) begin
                active <= 1'b0;
            end else if (active) begin
                cnt <= cnt - 32'd1;
            end
            status <= (clear ? 2'b00 : status) | (load ? stat_in : 2'b00);
            if (fire)
                irq <= 1'b1;
            else if (clear)
                irq <= 1'b0;
        end
    end

    AST_IRQ_ON_FIRE: assert property (@(posedge clk) disable iff (rst)
        fire |=> irq);                                                    // R10
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (clear && !fire) |=> !irq);                                       // R12
    AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
        load |-> !active);                                                // R11
    AST_STATUS_SET: assert property (@(posedge clk) disable iff (rst)
        load |=> ((status & $past(stat_in)) == $past(stat_in)));          // R9
endmodule

// File: rtl/cart_dma.sv
module cart_dma
    import cdma_pkg::*;
#(
    parameter int          DRAM_AW     = 23,
    parameter int          SRAM_AW     = 15,
    parameter logic [31:0] ROM_BYTES   = 32'h0100_0000,
    parameter logic [31:0] FIXED_DELAY = 32'd4096
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic [2:0]            reg_sel,
    input  logic [31:0]           reg_wdata,
    output logic                  busy,
    output logic [1:0]            status,
    output logic                  irq,
    output logic                  dram_en,
    output logic                  dram_we,
    output logic [DRAM_AW-1:0]    dram_addr,
    output logic [7:0]            dram_wdata,
    input  logic [7:0]            dram_rdata,
    output logic                  cart_en,
    output logic                  cart_we,
    output logic                  cart_rom,
    output logic [CART_OFF_W-1:0] cart_addr,
    output logic [7:0]            cart_wdata,
    input  logic [7:0]            cart_rdata
);
    localparam logic [31:0] DRAM_LIMIT = (32'd1 << DRAM_AW) - 32'd1;

    logic [31:0] cart_q;
    logic [31:0] dram_q;
    logic [31:0] pend_delay;
    logic [1:0]  pend_stat;
    logic        len_wr;
    logic        to_dram;
    logic        start_ok;
    logic        mv_start;
    logic        mv_active;
    logic        mv_last;
    logic        tm_active;
    logic        tm_load;
    logic        clr;
    plan_t       plan;
    logic        plan_unused;

    assign len_wr   = reg_we && (reg_sel == RS_LEN_OUT || reg_sel == RS_LEN_IN);
    assign to_dram  = (reg_sel == RS_LEN_IN);
    assign start_ok = len_wr && !busy;
    assign mv_start = start_ok && (plan.nbytes != 32'd0);
    assign tm_load  = (start_ok && plan.nbytes == 32'd0) || mv_last;
    assign clr      = reg_we && (reg_sel == RS_CLEAR);
    assign busy     = mv_active || tm_active;
    assign plan_unused = ^plan.dram_base[31:DRAM_AW];

    always_ff @(posedge clk) begin
        if (rst) begin
            cart_q     <= '0;
            dram_q     <= '0;
            pend_delay <= '0;
            pend_stat  <= 2'b00;
        end else begin
            if (reg_we && reg_sel == RS_CART) cart_q <= reg_wdata;
            if (reg_we && reg_sel == RS_DRAM) dram_q <= reg_wdata;
            if (start_ok) begin
                pend_delay <= plan.delay;
                pend_stat  <= plan.stat;
            end
        end
    end

    cdma_decode #(
        .ROM_BYTES  (ROM_BYTES),
        .DRAM_LIMIT (DRAM_LIMIT),
        .FIXED_DELAY(FIXED_DELAY)
    ) u_decode (
        .to_dram  (to_dram),
        .cart_addr(cart_q),
        .dram_addr(dram_q),
        .len_word (reg_wdata),
        .plan     (plan)
    );

    cdma_mover #(
        .DRAM_AW(DRAM_AW),
        .SRAM_AW(SRAM_AW)
    ) u_mover (
        .clk       (clk),
        .rst       (rst),
        .start     (mv_start),
        .to_dram_i (plan.to_dram),
        .rom_i     (plan.path == P_ROM),
        .off_i     (plan.cart_off),
        .dram_i    (plan.dram_base[DRAM_AW-1:0]),
        .nbytes_i  (plan.nbytes),
        .active_o  (mv_active),
        .last_o    (mv_last),
        .dram_en   (dram_en),
        .dram_we   (dram_we),
        .dram_addr (dram_addr),
        .dram_wdata(dram_wdata),
        .dram_rdata(dram_rdata),
        .cart_en   (cart_en),
        .cart_we   (cart_we),
        .cart_rom  (cart_rom),
        .cart_addr (cart_addr),
        .cart_wdata(cart_wdata),
        .cart_rdata(cart_rdata)
    );

    cdma_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tm_load),
        .delay   (mv_last ? pend_delay : plan.delay),
        .stat_in (mv_last ? pend_stat  : plan.stat),
        .clear   (clr),
        .active_o(tm_active),
        .irq     (irq),
        .status  (status)
    );

    AST_ROM_END: assert property (@(posedge clk) disable iff (rst)
        (cart_en && cart_rom) |-> ({{(32-CART_OFF_W){1'b0}}, cart_addr ^ CART_OFF_W'(3)} < ROM_BYTES)); // R6
    AST_DRAM_END: assert property (@(posedge clk) disable iff (rst)
        (dram_en && cart_rom) |-> ({{(32-DRAM_AW){1'b0}}, dram_addr ^ DRAM_AW'(3)} < DRAM_LIMIT));       // R7
    AST_ONE_DIR: assert property (@(posedge clk) disable iff (rst)
        dram_en |-> (dram_we != cart_we));                                // R1
endmodule

// File: tb/test_cart_dma.sv
`timescale 1ns/1ps
module test_cart_dma;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [2:0]  reg_sel;
    logic [31:0] reg_wdata;
    logic        busy, irq;
    logic [1:0]  status;
    logic        dram_en, dram_we, cart_en, cart_we, cart_rom;
    logic [22:0] dram_addr;
    logic [25:0] cart_addr;
    logic [7:0]  dram_wdata, dram_rdata, cart_wdata, cart_rdata;

    int nvec = 0;
    int nbad = 0;
    int cyc  = 0;

    always #2.5 clk = ~clk;

    cart_dma i_cart_dma (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .busy(busy), .status(status), .irq(irq),
        .dram_en(dram_en), .dram_we(dram_we), .dram_addr(dram_addr),
        .dram_wdata(dram_wdata), .dram_rdata(dram_rdata),
        .cart_en(cart_en), .cart_we(cart_we), .cart_rom(cart_rom), .cart_addr(cart_addr),
        .cart_wdata(cart_wdata), .cart_rdata(cart_rdata)
    );

    function automatic logic [7:0] dpat(input logic [22:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction
    function automatic logic [7:0] cpat(input logic rom, input logic [25:0] a);
        return rom ? (a[7:0] + a[15:8] + 8'h11) : (a[7:0] ^ 8'hC3);
    endfunction

    assign dram_rdata = dpat(dram_addr);
    assign cart_rdata = cpat(cart_rom, cart_addr);

    typedef struct {
        logic        dwe;
        logic [22:0] da;
        logic        cwe;
        logic        crom;
        logic [25:0] ca;
        logic [7:0]  d;
    } acc_t;
    acc_t q[$];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        acc_t e;
        if (!rst && dram_en) begin
            if (q.size() == 0) begin
                nvec++; nbad++;
                $display("FAIL R1 unexpected access actual=%0h expected=none", dram_addr);
            end else begin
                e = q.pop_front();
                check("R1 dram_we",  dram_we,  e.dwe);
                check("R3 dram_addr", dram_addr, e.da);
                check("R1 cart_we",  cart_we,  e.cwe);
                check("R5 cart_rom", cart_rom, e.crom);
                check("R2 cart_addr", cart_addr, e.ca);
                check("R3 data", e.dwe ? dram_wdata : cart_wdata, e.d);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            nbad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // expectation model from the requirements
    task automatic model(input bit to_dram, input logic [31:0] cart, input logic [31:0] dram,
                         input logic [31:0] len, output longint n, output longint d,
                         output logic [1:0] st, output bit rom, output logic [25:0] off);
        longint ln;
        longint o;
        ln = longint'(len[23:0]) + 1;
        n = 0; d = 4096; st = 2'b01; rom = 0; off = '0;
        if (cart >= 32'h0800_0000 && cart < 32'h0801_0000) begin
            n = ln;
            off = 26'(cart - 32'h0800_0000);
        end else if (to_dram && cart >= 32'h1000_0000 && cart < 32'h1FC0_0000) begin
            o  = longint'(cart[25:0]);
            st = 2'b11;
            if (o > 64'h100_0000 || dram > 32'h7F_FFFF) begin
                d = 0;
            end else begin
                if (ln > 64'h100_0000 - o) ln = 64'h100_0000 - o;
                if (ln > 64'h7F_FFFF - longint'(dram)) ln = 64'h7F_FFFF - longint'(dram);
                n = ln; d = ln / 8; rom = 1; off = 26'(o);
            end
        end
    endtask

    task automatic run(input string tag, input logic [2:0] lsel, input logic [31:0] cart,
                       input logic [31:0] dram, input logic [31:0] len,
                       input bit mid_write, input bit clr_at_fire);
        longint n, d, c;
        logic [1:0] st;
        bit rom, fired, to_dram;
        logic [25:0] off;
        logic [31:0] t;
        acc_t e;
        to_dram = (lsel == 3'd3);
        model(to_dram, cart, dram, len, n, d, st, rom, off);
        wr(3'd4, 32'd0);
        check({tag, " R12 irq cleared"}, irq, 1'b0);
        wr(3'd0, cart);
        wr(3'd1, dram);
        for (longint k = 0; k < n; k++) begin
            t = dram + 32'(k);
            e.dwe = to_dram; e.cwe = !to_dram; e.crom = rom;
            e.da = t[22:0] ^ 23'd3;
            e.ca = rom ? ((off + 26'(k)) ^ 26'd3) : (((off + 26'(k)) & 26'h7FFF) ^ 26'd3);
            e.d  = to_dram ? cpat(rom, e.ca) : dpat(e.da);
            q.push_back(e);
        end
        wr(lsel, len);
        if (clr_at_fire) begin
            reg_we = 1'b1; reg_sel = 3'd4; reg_wdata = '0;
        end
        check({tag, " R1 busy after start"}, busy, 1'b1);
        c = 0; fired = 0;
        while (!fired && c < 6000) begin
            @(negedge clk);
            c++;
            if (c == 1 && clr_at_fire) reg_we = 1'b0;
            if (mid_write && c == 2) begin
                reg_we = 1'b1; reg_sel = 3'd3; reg_wdata = 32'd0;
            end
            if (mid_write && c == 3) reg_we = 1'b0;
            if (irq) fired = 1;
        end
        check({tag, " R10 irq cycle"}, c, n + d + 1);
        check({tag, " R9 status"}, status, clr_at_fire ? 2'b00 : st);
        check({tag, " R6 R7 bytes left"}, q.size(), 0);
        repeat (3) @(negedge clk);
        check({tag, " R11 idle after irq"}, busy, 1'b0);
        check({tag, " R12 irq held"}, irq, 1'b1);
    endtask

    initial begin
        rst = 1'b1; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset busy", busy, 1'b0);
        check("R12 reset irq", irq, 1'b0);
        check("R9 reset status", status, 2'b00);
        check("R1 reset no access", dram_en, 1'b0);

        run("R2 sram to dram",      3'd3, 32'h0800_0010, 32'h0000_0100, 32'd5,  0, 0);
        run("R2 sram wrap to cart", 3'd2, 32'h0800_FFFE, 32'h0000_0203, 32'd3,  0, 0);
        run("R4 ignored region",    3'd3, 32'h0600_0100, 32'h0000_0000, 32'd7,  0, 0);
        run("R4 rom to cart",       3'd2, 32'h1000_0000, 32'h0000_0000, 32'd7,  0, 0);
        run("R4 high region",       3'd3, 32'h1FC0_0000, 32'h0000_0000, 32'd7,  0, 0);
        run("R5 rom normal",        3'd3, 32'h1000_0040, 32'h0000_1000, 32'd31, 0, 0);
        run("R6 rom end clip",      3'd3, 32'h10FF_FFF8, 32'h0000_2000, 32'd63, 0, 0);
        run("R6 offset at rom end", 3'd3, 32'h1100_0000, 32'h0000_2000, 32'd63, 0, 0);
        run("R7 dram end clip",     3'd3, 32'h1000_0000, 32'h007F_FFF0, 32'd63, 0, 0);
        run("R8 dram out of range", 3'd3, 32'h1000_0000, 32'h0080_0000, 32'd15, 0, 0);
        run("R8 R12 clear at fire", 3'd3, 32'h1100_0010, 32'h0000_0000, 32'd15, 0, 1);
        run("R11 start while busy", 3'd3, 32'h1000_0100, 32'h0000_0040, 32'd15, 1, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule